// File: doc/BRIEF.md
# Dual-Bank Video Playback Sequencer

This block walks through video frames held in external memory and issues one frame address per frame period. Two playback banks each hold a base address, a number of frames and a number of repetitions. In toggle mode the sequencer plays one bank to the end and then switches to the other. Each switch raises a pending interrupt bit. A host can therefore rewrite the bank that has just finished while the other bank is on screen, and chain any number of clips together.

A free-running frame timer sets the pace. It is reloaded from a period register that holds a count of clock cycles. The host steers playback through a control word:
- A write with the play bit set restarts playback at the next frame tick, at the bank chosen by the pointer bit.
- A write without play changes only the modes. Playback then keeps running, so the host can ask for a stop once the current bank is done.
- A stop bit halts playback at the next frame tick.

Top module: `video_bank_sequencer`

## Requirements
- R1: Register word addresses are: 0 control, 1 frame period, 2 bank-0 base, 3 bank-0 setup, 4 bank-1 base, 5 bank-1 setup, 6 interrupt enable, 7 interrupt pending (read), 8 interrupt clear (write).
  - Control bits: play=0, stop=1, auto-stop=2, repeat=3, toggle=4, bank pointer=5. On a control read, bit 0 returns the running flag.
  - Setup registers hold the frame count in [15:0] and the loop count in [31:16].
  - Read data appears the cycle after the read enable.
  - After reset, nothing is running, no frame is issued and the IRQ is low.
- R2: While playing, successive frames are issued exactly one frame period apart. A period of 0 counts as 1.
- R3: The address of frame i of a bank is the bank base plus i times FRAME_BYTES. The index restarts at 0 on every loop, and a bank plays its frame count times its loop count.
- R4: With toggle set, a finished bank hands over to the other bank (0 to 1, and 1 back to 0). The other bank's frame 0 is issued on the same tick.
- R5: Every bank switch sets pending bit 0. The pending register reads the raw bit whatever the enable setting, and the IRQ output is high while an enabled pending bit is set.
- R6: Writing 1 to a bit of the clear register clears that pending bit and drops the IRQ.
- R7: A control write with play set restarts at the pointed bank's frame 0 on the next tick, even if the current bank is in mid-play.
- R8: A control write with auto-stop set and play clear lets the current bank finish. Playback then stops with no switch and no pending bit.
- R9: With repeat set and toggle clear, the active bank repeats without end and no pending bit is raised.
- R10: A stop request halts playback at the next tick. No further frames are issued and the running flag clears.
- R11: A loop count of 0 plays as 1. A frame count of 0 makes the bank complete at once, with no frame issued from it.
- R12: A new base written to the idle bank after a switch is used the next time that bank becomes active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Register word address |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data, registered |
| frame_valid | output | 1 | One-cycle pulse per issued frame |
| frame_addr | output | AW | Memory address of the issued frame |
| active_bank | output | 1 | Bank currently playing |
| running | output | 1 | Playback active |
| irq | output | 1 | Host interrupt request |

## Verification
Some rules are checked on every cycle:
- No frame is issued unless playback is running.
- The active bank changes only on a frame tick.
- A bank switch leaves the pending bit set.
- A clear write removes the pending bit.

Other behaviour can only be shown by the bench's scenarios. This covers the frame order across loops and bank switches, the spacing between frames, restart on play, run-to-end with auto-stop, the endless repeat mode, the zero-count cases and rewriting the idle bank in mid-run.

// File: rtl/vbs_pkg.sv
package vbs_pkg;
  localparam int REG_DW = 32;
  localparam int CNT_W  = 16;

  typedef enum logic [3:0] {
    RA_CTRL    = 4'd0,
    RA_PERIOD  = 4'd1,
    RA_BASE0   = 4'd2,
    RA_SETUP0  = 4'd3,
    RA_BASE1   = 4'd4,
    RA_SETUP1  = 4'd5,
    RA_IRQ_EN  = 4'd6,
    RA_IRQ_PND = 4'd7,
    RA_IRQ_CLR = 4'd8
  } reg_addr_e;

  // bit 0 play ... bit 5 bank pointer
  typedef struct packed {
    logic ptr;
    logic toggle;
    logic repeat_on;
    logic autostop;
    logic stop;
    logic play;
  } ctrl_t;

  typedef struct packed {
    logic [CNT_W-1:0] loops;
    logic [CNT_W-1:0] frames;
  } bank_setup_t;
endpackage

// File: rtl/vbs_frame_timer.sv
module vbs_frame_timer #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] period,
  output logic          tick
);
  logic [CW-1:0] cnt;

  assign tick = (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (tick) cnt <= (period == '0) ? '0 : period - 1'b1;
    else           cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/vbs_irq_unit.sv
module vbs_irq_unit #(
  parameter int NSRC = 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] set_evt,
  input  logic            en_wr,
  input  logic [NSRC-1:0] en_val,
  input  logic            clr_wr,
  input  logic [NSRC-1:0] clr_val,
  output logic [NSRC-1:0] en,
  output logic [NSRC-1:0] pend,
  output logic            irq
);
  for (genvar i = 0; i < NSRC; i++) begin : g_src
    always_ff @(posedge clk) begin
      if (rst) begin
        en[i]   <= 1'b0;
        pend[i] <= 1'b0;
      end else begin
        if (en_wr) en[i] <= en_val[i];
        if (set_evt[i])                 pend[i] <= 1'b1;
        else if (clr_wr && clr_val[i])  pend[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(pend & en);
  end
endmodule

// File: rtl/vbs_engine.sv
module vbs_engine
  import vbs_pkg::*;
#(
  parameter int AW          = 32,
  parameter int FRAME_BYTES = 4096
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          ctrl_wr,
  input  ctrl_t         ctrl_in,
  input  logic [AW-1:0] base0,
  input  logic [AW-1:0] base1,
  input  bank_setup_t   setup0,
  input  bank_setup_t   setup1,
  output logic          frame_valid,
  output logic [AW-1:0] frame_addr,
  output logic          bank,
  output logic          running,
  output logic          swap,
  output ctrl_t         mode
);
  localparam logic [AW-1:0] FSTEP = AW'(FRAME_BYTES);

  logic             pend_play, pend_stop, start_ptr;
  logic [CNT_W-1:0] fidx, lidx, n_fidx, n_lidx;
  logic             n_run, n_bank, emit;
  logic             last_frame, last_loop, endless;
  logic [CNT_W-1:0] loops_eff;
  bank_setup_t      cur, oth, st_ptr;
  logic [AW-1:0]    n_base;

  assign cur       = bank ? setup1 : setup0;
  assign oth       = bank ? setup0 : setup1;
  assign st_ptr    = start_ptr ? setup1 : setup0;
  assign loops_eff = (cur.loops == '0) ? CNT_W'(1) : cur.loops;
  assign endless   = mode.repeat_on & ~mode.toggle;
  assign last_frame = (cur.frames == '0) ||
                      ({1'b0, fidx} + 1'b1 >= {1'b0, cur.frames});
  assign last_loop  = (cur.frames == '0) ||
                      (!endless && ({1'b0, lidx} + 1'b1 >= {1'b0, loops_eff}));

  always_comb begin
    n_run  = running;
    n_bank = bank;
    n_fidx = fidx;
    n_lidx = lidx;
    emit   = 1'b0;
    swap   = 1'b0;
    if (tick) begin
      if (pend_stop) begin
        n_run = 1'b0;
      end else if (pend_play) begin
        n_run  = 1'b1;
        n_bank = start_ptr;
        n_fidx = '0;
        n_lidx = '0;
        emit   = (st_ptr.frames != '0);
      end else if (running) begin
        if (!last_frame) begin
          n_fidx = fidx + 1'b1;
          emit   = 1'b1;
        end else if (!last_loop) begin
          n_fidx = '0;
          n_lidx = endless ? lidx : lidx + 1'b1;
          emit   = 1'b1;
        end else if (mode.autostop || !mode.toggle) begin
          n_run = 1'b0;
        end else begin
          swap   = 1'b1;
          n_bank = ~bank;
          n_fidx = '0;
          n_lidx = '0;
          emit   = (oth.frames != '0);
        end
      end
    end
  end

  assign n_base = n_bank ? base1 : base0;

  always_ff @(posedge clk) begin
    if (rst) begin
      running     <= 1'b0;
      bank        <= 1'b0;
      fidx        <= '0;
      lidx        <= '0;
      frame_valid <= 1'b0;
      frame_addr  <= '0;
      pend_play   <= 1'b0;
      pend_stop   <= 1'b0;
      start_ptr   <= 1'b0;
      mode        <= '0;
    end else begin
      running     <= n_run;
      bank        <= n_bank;
      fidx        <= n_fidx;
      lidx        <= n_lidx;
      frame_valid <= emit;
      if (emit) frame_addr <= n_base + AW'(n_fidx) * FSTEP;
      if (tick) begin
        pend_play <= 1'b0;
        pend_stop <= 1'b0;
      end
      if (ctrl_wr) begin
        mode <= ctrl_in;
        if (ctrl_in.play) begin
          pend_play <= 1'b1;
          start_ptr <= ctrl_in.ptr;
        end
        if (ctrl_in.stop) pend_stop <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/video_bank_sequencer.sv
module video_bank_sequencer
  import vbs_pkg::*;
#(
  parameter int          AW          = 32,
  parameter int          FRAME_BYTES = 4096,
  parameter logic [31:0] DEF_PERIOD  = 32'd16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [3:0]    addr,
  input  logic [31:0]   wr_data,
  output logic [31:0]   rd_data,
  output logic          frame_valid,
  output logic [AW-1:0] frame_addr,
  output logic          active_bank,
  output logic          running,
  output logic          irq
);
  localparam int NSRC = 1;

  logic [REG_DW-1:0] period;
  logic [AW-1:0]     base0, base1;
  bank_setup_t       setup0, setup1;
  logic              tick, swap;
  ctrl_t             mode;
  logic [NSRC-1:0]   irq_en, irq_pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      period <= DEF_PERIOD;
      base0  <= '0;
      base1  <= '0;
      setup0 <= '0;
      setup1 <= '0;
    end else if (wr_en) begin
      case (addr)
        RA_PERIOD: period <= wr_data;
        RA_BASE0:  base0  <= wr_data[AW-1:0];
        RA_SETUP0: setup0 <= wr_data;
        RA_BASE1:  base1  <= wr_data[AW-1:0];
        RA_SETUP1: setup1 <= wr_data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else if (rd_en) begin
      case (addr)
        RA_CTRL:    rd_data <= {26'd0, mode.ptr, mode.toggle, mode.repeat_on,
                                mode.autostop, 1'b0, running};
        RA_PERIOD:  rd_data <= period;
        RA_BASE0:   rd_data <= 32'(base0);
        RA_SETUP0:  rd_data <= setup0;
        RA_BASE1:   rd_data <= 32'(base1);
        RA_SETUP1:  rd_data <= setup1;
        RA_IRQ_EN:  rd_data <= 32'(irq_en);
        RA_IRQ_PND: rd_data <= 32'(irq_pend);
        default:    rd_data <= '0;
      endcase
    end
  end

  vbs_frame_timer #(.CW(REG_DW)) u_tmr (
    .clk(clk), .rst(rst), .period(period), .tick(tick)
  );

  vbs_engine #(.AW(AW), .FRAME_BYTES(FRAME_BYTES)) u_eng (
    .clk(clk), .rst(rst), .tick(tick),
    .ctrl_wr(wr_en && addr == RA_CTRL), .ctrl_in(ctrl_t'(wr_data[5:0])),
    .base0(base0), .base1(base1), .setup0(setup0), .setup1(setup1),
    .frame_valid(frame_valid), .frame_addr(frame_addr), .bank(active_bank),
    .running(running), .swap(swap), .mode(mode)
  );

  vbs_irq_unit #(.NSRC(NSRC)) u_irq (
    .clk(clk), .rst(rst), .set_evt(swap),
    .en_wr(wr_en && addr == RA_IRQ_EN), .en_val(wr_data[NSRC-1:0]),
    .clr_wr(wr_en && addr == RA_IRQ_CLR), .clr_val(wr_data[NSRC-1:0]),
    .en(irq_en), .pend(irq_pend), .irq(irq)
  );
endmodule

// File: rtl/video_bank_sequencer_chk.sv
module video_bank_sequencer_chk (
  input logic        clk,
  input logic        rst,
  input logic        wr_en,
  input logic [3:0]  addr,
  input logic [31:0] wr_data,
  input logic        frame_valid,
  input logic        running,
  input logic        active_bank,
  input logic        irq,
  input logic        tick,
  input logic        swap,
  input logic        pend0
);
  // R10: frames only come out while playback runs
  a_r10_frame_needs_run: assert property (@(posedge clk) disable iff (rst)
    frame_valid |-> running);

  // R4: the bank may only move on a frame tick
  a_r4_bank_on_tick: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(active_bank));

  // R5: a bank switch leaves the pending bit set
  a_r5_swap_pends: assert property (@(posedge clk) disable iff (rst)
    swap |=> pend0);

  // R6: clear write removes the pending bit when no switch coincides
  a_r6_clear_works: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == 4'd8 && wr_data[0] && !swap) |=> !pend0);

  // R1: quiet outputs on the first cycle out of reset
  a_r1_quiet_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!irq && !frame_valid && !running));
endmodule

bind video_bank_sequencer video_bank_sequencer_chk u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
  .frame_valid(frame_valid), .running(running), .active_bank(active_bank),
  .irq(irq), .tick(tick), .swap(swap), .pend0(irq_pend[0])
);

// File: tb/sim_video_bank_sequencer.sv
`timescale 1ns/1ps
module sim_video_bank_sequencer;
  localparam int FB = 4096;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        frame_valid, active_bank, running, irq;
  logic [31:0] frame_addr;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;
  logic [31:0] cap_addr [0:255];
  logic        cap_bank [0:255];
  int          cap_cyc  [0:255];
  int          cap_n = 0;
  logic [31:0] exp_a [0:63];
  logic        exp_b [0:63];

  video_bank_sequencer #(.AW(32), .FRAME_BYTES(FB), .DEF_PERIOD(32'd16)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .frame_valid(frame_valid),
    .frame_addr(frame_addr), .active_bank(active_bank), .running(running),
    .irq(irq)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc++;

  always @(negedge clk) begin
    if (!rst && frame_valid && cap_n < 256) begin
      cap_addr[cap_n] = frame_addr;
      cap_bank[cap_n] = active_bank;
      cap_cyc[cap_n]  = cyc;
      cap_n++;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ctl(bit play, bit stop, bit auto_s, bit rep,
                                      bit tog, bit ptr);
    return {26'd0, ptr, tog, rep, auto_s, stop, play};
  endfunction

  function automatic logic [31:0] setup(int frames, int loops);
    return {loops[15:0], frames[15:0]};
  endfunction

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0; d = rd_data;
  endtask

  task automatic wait_frames(input int n, input int limit);
    for (int i = 0; i < limit && cap_n < n; i++) @(negedge clk);
  endtask

  task automatic halt(input int p);
    wr(4'd0, ctl(0, 1, 0, 0, 0, 0));
    repeat (p + 4) @(negedge clk);
    wr(4'd8, 32'd1);
  endtask

  // expected order: each bank plays frames x max(loops,1), then the other bank
  task automatic build_seq(input bit ptr, input int fc0, input int lc0,
                           input int fc1, input int lc1, input logic [31:0] b0,
                           input logic [31:0] b1, input int m);
    int k = 0;
    bit b = ptr;
    while (k < m) begin
      int fc = b ? fc1 : fc0;
      int lc = b ? lc1 : lc0;
      if (lc == 0) lc = 1;
      for (int l = 0; l < lc; l++)
        for (int f = 0; f < fc; f++)
          if (k < m) begin
            exp_a[k] = (b ? b1 : b0) + f * FB;
            exp_b[k] = b;
            k++;
          end
      b = ~b;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state and register map
    chk(!running && !frame_valid && !irq, "R1 reset outputs", {running, frame_valid, irq}, 0);
    rd(4'd7, d); chk(d == 0, "R1 pending after reset", d, 0);
    rd(4'd1, d); chk(d == 16, "R1 default period", d, 16);
    wr(4'd3, setup(7, 3)); rd(4'd3, d);
    chk(d == setup(7, 3), "R1 setup readback", d, setup(7, 3));

    // R2 R3 R4 R5: random two-bank runs
    for (int t = 0; t < 6; t++) begin
      int p   = 2 + $urandom_range(0, 4);
      int fc0 = 1 + $urandom_range(0, 3), fc1 = 1 + $urandom_range(0, 3);
      int lc0 = $urandom_range(0, 3),     lc1 = $urandom_range(0, 3);
      bit ptr = 1'($urandom_range(0, 1));
      logic [31:0] b0 = {$urandom_range(0, 255), 20'h0};
      logic [31:0] b1 = {$urandom_range(256, 511), 20'h0};
      bit ok_a = 1, ok_s = 1;
      wr(4'd1, p); wr(4'd2, b0); wr(4'd3, setup(fc0, lc0));
      wr(4'd4, b1); wr(4'd5, setup(fc1, lc1)); wr(4'd6, 32'd1);
      build_seq(ptr, fc0, lc0, fc1, lc1, b0, b1, 12);
      cap_n = 0;
      wr(4'd0, ctl(1, 0, 0, 0, 1, ptr));
      wait_frames(12, 40 * p * 12);
      for (int k = 0; k < 12; k++) begin
        if (cap_addr[k] !== exp_a[k] || cap_bank[k] !== exp_b[k]) begin
          if (ok_a) chk(0, "R3/R4 frame order", cap_addr[k], exp_a[k]);
          ok_a = 0;
        end
        if (k > 0 && (cap_cyc[k] - cap_cyc[k-1]) != p) begin
          if (ok_s) chk(0, "R2 frame spacing", cap_cyc[k] - cap_cyc[k-1], p);
          ok_s = 0;
        end
      end
      if (ok_a) chk(1, "R3/R4 frame order", 0, 0);
      if (ok_s) chk(1, "R2 frame spacing", 0, 0);
      rd(4'd7, d); chk(d[0] == 1, "R5 switch pends", d, 1);
      chk(irq == 1, "R5 irq enabled", irq, 1);
      halt(p);
      rd(4'd7, d); chk(d[0] == 0, "R6 clear pending", d, 0);
      @(negedge clk); chk(irq == 0, "R6 irq drops", irq, 0);
    end

    // R7 play mid-bank restarts at pointed bank
    wr(4'd1, 4); wr(4'd2, 32'h0010_0000); wr(4'd3, setup(8, 1));
    wr(4'd4, 32'h0020_0000); wr(4'd5, setup(3, 1));
    cap_n = 0;
    wr(4'd0, ctl(1, 0, 0, 0, 1, 0));
    wait_frames(2, 200);
    wr(4'd0, ctl(1, 0, 0, 0, 1, 1));
    wait_frames(3, 200);
    chk(cap_addr[2] == 32'h0020_0000 && cap_bank[2] == 1, "R7 restart at pointer",
        cap_addr[2], 32'h0020_0000);
    chk(cap_cyc[2] - cap_cyc[1] == 4, "R7 no wait for bank end", cap_cyc[2] - cap_cyc[1], 4);
    halt(4);

    // R8 auto-stop lets bank finish then halts
    wr(4'd3, setup(3, 1));
    cap_n = 0;
    wr(4'd0, ctl(1, 0, 0, 0, 1, 0));
    wait_frames(1, 200);
    wr(4'd0, ctl(0, 0, 1, 0, 1, 0));
    repeat (40) @(negedge clk);
    chk(cap_n == 3, "R8 bank runs to end", cap_n, 3);
    chk(running == 0, "R8 stopped", running, 0);
    rd(4'd7, d); chk(d[0] == 0, "R8 no switch pending", d, 0);
    rd(4'd0, d); chk(d[0] == 0, "R8 control reads idle", d, 0);

    // R9 endless repeat
    wr(4'd3, setup(2, 1));
    cap_n = 0;
    wr(4'd0, ctl(1, 0, 0, 1, 0, 0));
    wait_frames(7, 300);
    begin
      bit ok = 1;
      for (int k = 0; k < 7; k++)
        if (cap_addr[k] !== 32'h0010_0000 + (k % 2) * FB || cap_bank[k] !== 0) ok = 0;
      chk(ok && cap_n >= 7, "R9 repeats bank", cap_n, 7);
    end
    rd(4'd7, d); chk(d[0] == 0, "R9 no pending", d, 0);

    // R10 stop at next tick
    wr(4'd0, ctl(0, 1, 0, 1, 0, 0));
    repeat (6) @(negedge clk);
    chk(running == 0, "R10 running clears", running, 0);
    d = cap_n;
    repeat (20) @(negedge clk);
    chk(cap_n == d, "R10 no frames after stop", cap_n, d);

    // R11 zero frame count and zero loop count; R5 masked irq
    wr(4'd6, 32'd0);
    wr(4'd3, setup(0, 2)); wr(4'd5, setup(2, 0));
    cap_n = 0;
    wr(4'd0, ctl(1, 0, 0, 0, 1, 0));
    wait_frames(3, 300);
    chk(cap_addr[0] == 32'h0020_0000 && cap_addr[1] == 32'h0020_0000 + FB &&
        cap_addr[2] == 32'h0020_0000 && cap_bank[0] == 1 && cap_bank[2] == 1,
        "R11 zero counts", cap_addr[2], 32'h0020_0000);
    rd(4'd7, d); chk(d[0] == 1 && irq == 0, "R5 masked pending", {d[0], irq}, 2);
    wr(4'd6, 32'd1); @(negedge clk);
    chk(irq == 1, "R5 enable raises irq", irq, 1);
    halt(4);

    // R12 rewrite idle bank after the switch
    wr(4'd1, 8); wr(4'd2, 32'h00A0_0000); wr(4'd3, setup(2, 1));
    wr(4'd4, 32'h00B0_0000); wr(4'd5, setup(2, 1));
    cap_n = 0;
    wr(4'd0, ctl(1, 0, 0, 0, 1, 0));
    for (int i = 0; i < 300 && !irq; i++) @(negedge clk);
    wr(4'd2, 32'h00C0_0000);
    wait_frames(5, 300);
    chk(cap_addr[2] == 32'h00B0_0000 && cap_addr[4] == 32'h00C0_0000,
        "R12 idle bank rewrite", cap_addr[4], 32'h00C0_0000);
    halt(8);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule